// File: doc/BRIEF.md
# Up/Down Counter with Enable-Clear and Hold

This block is a binary counter whose register moves up or down by one on each rising clock edge. The direction comes from a single select input. A hold input freezes the present value, and counting resumes from that value once hold is released. The enable input does not pause the counter. While enable is low the register is driven to zero, so deasserting enable restarts the count.

The control inputs are ranked in a fixed order. An active reset wins over everything. Next comes enable low, which clears the count. Hold comes after that and keeps the value. Counting in the selected direction comes last. The count wraps around at the parameterised width. The output comes straight from the register, so it changes only at a clock edge, except when reset is asserted.

Top module: `ud_counter_hold`

## Requirements
- R1: While `rst_n` is low, `count` is zero. Reset is asynchronous: `count` goes to zero as soon as `rst_n` falls, without waiting for a clock edge.
- R2: On a rising edge with `rst_n` high and `en` low, `count` becomes zero, whatever the values of `hold` and `up_down`.
- R3: On a rising edge with `en` high, `hold` low and `up_down` high, `count` increases by one.
- R4: On a rising edge with `en` high, `hold` low and `up_down` low, `count` decreases by one.
- R5: On a rising edge with `en` high and `hold` high, `count` keeps its value. Counting continues from that value after `hold` returns low.
- R6: When `count` is all ones and the counter increments, it wraps to zero.
- R7: When `count` is zero and the counter decrements, it wraps to all ones.
- R8: `count` is registered. A change on `en`, `up_down` or `hold` between clock edges has no effect on `count` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All updates happen on its rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low. |
| en | input | 1 | Enable. When low, the count is cleared to zero. |
| up_down | input | 1 | Direction: 1 counts up, 0 counts down. |
| hold | input | 1 | When high, the count keeps its value. |
| count | output | WIDTH | Registered count value. |

## Verification
The hardest states to reach are the two wrap boundaries and the conflicts between controls, in particular enable low arriving while hold is high. Counting from reset to all ones would take many cycles. The bench avoids this by decrementing once from zero, which lands on all ones, and then increments across the top edge. Random stimulus weights enable mostly high and hold mostly low, so runs of counting build up between clears. Directed steps apply enable low together with hold. They also assert reset asynchronously in the middle of a clock phase, and they change the inputs in the middle of a phase to check that the output waits for the edge.

// File: rtl/udc_pkg.sv
// Package: shared operation encoding for the up/down counter.
// Assumes: consumers only compare against the named values.
package udc_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_KEEP  = 2'd1,
        OP_INC   = 2'd2,
        OP_DEC   = 2'd3
    } udc_op_e;
endpackage

// File: rtl/udc_ctrl.sv
// Module: udc_ctrl
// Turns the three control inputs into one operation, using the ranking
// clear > keep > count. Assumes reset is handled by the register stage.
module udc_ctrl
    import udc_pkg::*;
(
    input  logic    en,
    input  logic    up_down,
    input  logic    hold,
    output udc_op_e op
);
    // Pick the operation by priority.
    always_comb begin
        if (!en)          op = OP_CLEAR;
        else if (hold)    op = OP_KEEP;
        else if (up_down) op = OP_INC;
        else              op = OP_DEC;
    end
endmodule

// File: rtl/udc_step.sv
// Module: udc_step
// Computes the next count from the present count and the operation.
// Assumes modular arithmetic at WIDTH bits (natural wrap).
module udc_step
    import udc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  udc_op_e          op,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] inc_val;
    logic [WIDTH-1:0] dec_val;

    // Both neighbours of the present value; the adders wrap by width.
    always_comb begin
        inc_val = cur + ONE;
        dec_val = cur - ONE;
    end

    // Select the next value according to the operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = ZERO;
            OP_KEEP:  nxt = cur;
            OP_INC:   nxt = inc_val;
            OP_DEC:   nxt = dec_val;
            default:  nxt = ZERO;
        endcase
    end
endmodule

// File: rtl/udc_reg.sv
// Module: udc_reg
// WIDTH-bit state register with asynchronous active-low clear.
// Assumes rst_n is released synchronously to clk by the surrounding chip.
module udc_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture the next value; clear immediately on reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ud_counter_hold.sv
// Module: ud_counter_hold
// Up/down counter: en low clears, hold keeps, otherwise count in the
// direction of up_down. Output is taken straight from the register.
// Assumes control inputs are synchronous to clk.
module ud_counter_hold
    import udc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             up_down,
    input  logic             hold,
    output logic [WIDTH-1:0] count
);
    udc_op_e          op;
    logic [WIDTH-1:0] cnt_d;
    logic [WIDTH-1:0] cnt_q;

    udc_ctrl u_ctrl (
        .en      (en),
        .up_down (up_down),
        .hold    (hold),
        .op      (op)
    );

    udc_step #(.WIDTH(WIDTH)) u_step (
        .cur (cnt_q),
        .op  (op),
        .nxt (cnt_d)
    );

    udc_reg #(.WIDTH(WIDTH)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cnt_d),
        .q     (cnt_q)
    );

    assign count = cnt_q;
endmodule

// File: rtl/udc_checker.sv
// Module: udc_checker
// Property checks on the counter's ports, bound into ud_counter_hold.
// Assumes the port values seen at each rising edge of clk.
module udc_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             up_down,
    input logic             hold,
    input logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic seen_edge;

    // Note that at least one rising edge has passed, for the reset check.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // R1
    always @(negedge clk) begin
        if (seen_edge === 1'b1 && rst_n === 1'b0)
            reset_zero_chk: assert (count == '0);
    end

    // R2
    clear_on_low_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> count == '0);

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hold && up_down) |=> count == WIDTH'($past(count) + 1'b1));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hold && !up_down) |=> count == WIDTH'($past(count) - 1'b1));

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hold) |=> $stable(count));

    // R6
    wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hold && up_down && count == ALL_ONES) |=> count == '0);

    // R7
    wrap_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hold && !up_down && count == '0) |=> count == ALL_ONES);
endmodule

bind ud_counter_hold udc_checker #(.WIDTH(WIDTH)) u_udc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .up_down (up_down),
    .hold    (hold),
    .count   (count)
);

// File: tb/tb_ud_counter_hold.sv
`timescale 1ns/1ps
// Bench: random and directed stimulus against a reference model.
module tb_ud_counter_hold;
    localparam int W = 8;
    localparam logic [W-1:0] TOP = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, up_down = 1'b0, hold = 1'b0;
    logic [W-1:0] count;
    logic [W-1:0] exp_q;
    int n_cmp = 0, n_bad = 0;

    ud_counter_hold #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .up_down(up_down),
        .hold(hold), .count(count)
    );

    always #2 clk = ~clk;

    function automatic logic [W-1:0] model(logic [W-1:0] c, logic e,
                                           logic ud, logic h);
        if (!e)      return '0;
        else if (h)  return c;
        else if (ud) return c + 1'b1;
        else         return c - 1'b1;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: count=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(logic e, logic ud, logic h, string tag);
        en = e; up_down = ud; hold = h;
        exp_q = model(exp_q, e, ud, h);
        @(negedge clk);
        check(tag, count, exp_q);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: count=%0d expected=%0d", count, exp_q);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        exp_q = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", count, '0);
        rst_n = 1'b1;
        step(1, 1, 0, "R3 up");
        step(1, 1, 0, "R3 up");
        step(1, 1, 0, "R3 up");
        check("R3 reached 3", count, W'(3));
        step(1, 0, 1, "R5 hold");
        step(1, 1, 1, "R5 hold");
        step(1, 0, 0, "R5 resume R4 down");
        step(0, 1, 1, "R2 clear over hold");
        step(1, 0, 0, "R7 wrap bottom");
        check("R7 all ones", count, TOP);
        step(1, 1, 0, "R6 wrap top");
        check("R6 zero", count, '0);
        step(1, 1, 0, "R3 up");
        step(1, 1, 0, "R3 up");
        // Change inputs mid-phase; the output must wait for the edge.
        #1 en = 1'b0;
        #0.5 check("R8 no change before edge", count, W'(2));
        en = 1'b1; up_down = 1'b1; hold = 1'b0;
        @(negedge clk);
        exp_q = model(exp_q, 1, 1, 0);
        check("R8 after edge", count, exp_q);
        // Asynchronous reset between edges.
        #0.5 rst_n = 1'b0;
        #0.5 check("R1 async reset", count, '0);
        exp_q = '0;
        @(negedge clk);
        check("R1 held in reset", count, '0);
        rst_n = 1'b1;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic e, ud, h;
            e  = ($urandom_range(0, 15) != 0);
            ud = $urandom_range(0, 1);
            h  = ($urandom_range(0, 5) == 0);
            step(e, ud, h, "R2-R7 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule